// File: doc/BRIEF.md
# Segment Access Permission Checker

This block sits in front of paging and vets every memory access against a segment descriptor. A small table of descriptors, each holding a base, an inclusive limit and a set of access-right bits, is loaded through a configuration port. A second configuration port loads three segment selector slots: code, data and stack. Each request carries an access kind (fetch, read, write, stack) and a 32-bit offset with a byte count. The block picks the selector slot that the kind implies and uses it to find the descriptor. It then checks the rights and the byte span. It answers one cycle later with either the linear address or a fault cause.

Fetches are bound to the code slot and every other data access to the data or stack slot. Two descriptors that cover disjoint ranges therefore give no-execute protection for the data range without any page-level execute bit. Descriptors with base zero, a limit of all ones and every right set make the block a pass-through. The split between code and data can only change when a descriptor or selector is rewritten.

Top module: `segchk_top`

## Requirements
- R1: After reset, every descriptor is absent and every selector slot holds zero, so `rsp_valid` is 0 and any access answers fault 3.
- R2: A request taken while `req_valid` is 1 produces exactly one response with `rsp_valid` = 1 on the next clock edge. `rsp_valid` is 0 in the cycle after any cycle without a request.
- R3: The access kind selects the selector slot. Kind 0 (fetch) uses slot 0 (code). Kind 1 (read) and kind 2 (write) use slot 1 (data). Kind 3 (stack) uses slot 2 (stack). A selector write to slot 3 changes nothing.
- R4: Selector bits [15:3] are the descriptor index, and bits [2:0] are ignored. Index 0, an index of NUM_DESC or more, and a descriptor whose present bit (attribute bit 0) is clear all give fault 3 (invalid selector).
- R5: The attribute bits are: bit 1 execute, bit 2 read, bit 3 write. A fetch needs execute, a read needs read, a write needs write, and a stack access needs both read and write. A missing right gives fault 2 (type violation).
- R6: A request touches bytes offset through offset+size, where `req_size` is the byte count minus one. The limit is inclusive. The request gives fault 1 (limit violation) if the last byte exceeds the limit or lies past 2^32-1.
- R7: When several checks fail, the fault reported is the invalid selector first, then the type violation, then the limit violation.
- R8: With no fault, `rsp_linear` is the descriptor base plus the offset modulo 2^32 and `rsp_fault` is 0. With a fault, `rsp_linear` is 0.
- R9: A descriptor with base 0, limit 0xFFFFFFFF and all rights returns every offset unchanged with no fault.
- R10: When the code and data descriptors cover disjoint ranges, a fetch at an offset that reaches the data range faults, while a data access there succeeds.
- R11: A descriptor write takes effect for requests from the next cycle on. A request in the same cycle as the write is checked against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_desc_we | input | 1 | Descriptor write strobe |
| cfg_desc_idx | input | IDX_W | Descriptor entry to write |
| cfg_desc_base | input | 32 | Segment base |
| cfg_desc_limit | input | 32 | Inclusive segment limit |
| cfg_desc_attr | input | 4 | {write, read, execute, present} |
| cfg_sel_we | input | 1 | Selector write strobe |
| cfg_sel_slot | input | 2 | 0 code, 1 data, 2 stack, 3 ignored |
| cfg_sel_value | input | 16 | Selector value, index in bits [15:3] |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 stack |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 2 | Bytes touched minus one |
| rsp_valid | output | 1 | Response present |
| rsp_linear | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 type, 3 invalid selector |

## Verification
The bench targets the inclusive limit edge: a last byte exactly at the limit must pass, and one byte more must fault. A design that used a strict compare or checked only the first byte would get this wrong. It also probes the 4 GB wrap of a multi-byte span, which a 32-bit sum would miss, and a base plus offset that wraps around the address space. Fault priority is tested with requests that break several rules at once, so a design with the wrong ordering reports the wrong cause. The bench also checks rights swaps between code and data slots, the ignored selector slot and low selector bits, and a descriptor rewrite in the same cycle as a request, which a design that bypasses the write would answer with the new contents.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    localparam int ADDR_W     = 32;
    localparam int SEL_W      = 16;
    localparam int SEL_LOW_W  = 3;
    localparam int SEL_IDX_W  = SEL_W - SEL_LOW_W;
    localparam int NUM_SLOTS  = 3;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_STACK = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_TYPE  = 2'd2,
        FLT_SEL   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SLOT_CODE  = 2'd0,
        SLOT_DATA  = 2'd1,
        SLOT_STACK = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic ex;
        logic present;
    } attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        attr_t             attr;
    } desc_t;

    typedef struct packed {
        logic              valid;
        fault_e            fault;
        logic [ADDR_W-1:0] linear;
    } result_t;

    function automatic slot_e kind_to_slot(acc_kind_e kind);
        case (kind)
            ACC_FETCH: return SLOT_CODE;
            ACC_STACK: return SLOT_STACK;
            default:   return SLOT_DATA;
        endcase
    endfunction

    function automatic logic rights_ok(attr_t a, acc_kind_e kind);
        case (kind)
            ACC_FETCH: return a.ex;
            ACC_READ:  return a.rd;
            ACC_WRITE: return a.wr;
            default:   return a.rd & a.wr;
        endcase
    endfunction

    function automatic logic span_ok(logic [ADDR_W-1:0] off,
                                     logic [1:0]        size_m1,
                                     logic [ADDR_W-1:0] limit);
        logic [ADDR_W:0] last;
        last = {1'b0, off} + (ADDR_W+1)'(size_m1);
        return last <= {1'b0, limit};
    endfunction

endpackage

// File: rtl/segchk_desc_table.sv
module segchk_desc_table
    import segchk_pkg::*;
#(
    parameter  int NUM_DESC = 8,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 desc_we,
    input  logic [IDX_W-1:0]     desc_idx,
    input  desc_t                desc_wdata,
    input  logic                 sel_we,
    input  logic [1:0]           sel_slot,
    input  logic [SEL_W-1:0]     sel_wdata,
    input  acc_kind_e            look_kind,
    output desc_t                look_desc,
    output logic                 look_sel_bad
);

    localparam logic [SEL_IDX_W-1:0] NUM_DESC_L = SEL_IDX_W'(NUM_DESC);

    desc_t            desc_q [NUM_DESC];
    logic [SEL_W-1:0] sel_q  [NUM_SLOTS];

    for (genvar gi = 0; gi < NUM_DESC; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                desc_q[gi] <= '0;
            end else if (desc_we && desc_idx == IDX_W'(gi)) begin
                desc_q[gi] <= desc_wdata;
            end
        end
    end

    for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[gs] <= '0;
            end else if (sel_we && sel_slot == 2'(gs)) begin
                sel_q[gs] <= sel_wdata;
            end
        end
    end

    slot_e                slot;
    logic [SEL_W-1:0]     sel_cur;
    logic [SEL_IDX_W-1:0] sel_idx;
    logic                 idx_in_range;

    always_comb begin
        slot = kind_to_slot(look_kind);
        case (slot)
            SLOT_CODE:  sel_cur = sel_q[0];
            SLOT_STACK: sel_cur = sel_q[2];
            default:    sel_cur = sel_q[1];
        endcase
        sel_idx      = sel_cur[SEL_W-1:SEL_LOW_W];
        idx_in_range = (sel_idx != '0) && (sel_idx < NUM_DESC_L);
        look_desc    = desc_q[sel_idx[IDX_W-1:0]];
        look_sel_bad = !idx_in_range || !look_desc.attr.present;
    end

    // R3: a write aimed at slot 3 leaves every selector slot untouched
    a_r3_slot3_ignored: assert property (@(posedge clk) disable iff (rst)
        (sel_we && sel_slot == 2'd3) |=>
            ($stable(sel_q[0]) && $stable(sel_q[1]) && $stable(sel_q[2])));

    // R4: a null selector in the chosen slot is always reported as bad
    a_r4_null_selector: assert property (@(posedge clk) disable iff (rst)
        (sel_idx == '0) |-> look_sel_bad);

endmodule

// File: rtl/segchk_rule_check.sv
module segchk_rule_check
    import segchk_pkg::*;
(
    input  desc_t             desc,
    input  logic              sel_bad,
    input  acc_kind_e         kind,
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size_m1,
    output fault_e            fault,
    output logic [ADDR_W-1:0] linear
);

    logic type_pass;
    logic span_pass;

    always_comb begin
        type_pass = rights_ok(desc.attr, kind);
        span_pass = span_ok(offset, size_m1, desc.limit);
        fault     = FLT_NONE;
        linear    = '0;
        if (sel_bad) begin
            fault = FLT_SEL;
        end else if (!type_pass) begin
            fault = FLT_TYPE;
        end else if (!span_pass) begin
            fault = FLT_LIMIT;
        end else begin
            linear = desc.base + offset;
        end
    end

endmodule

// File: rtl/segchk_top.sv
module segchk_top
    import segchk_pkg::*;
#(
    parameter  int NUM_DESC = 8,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_desc_we,
    input  logic [IDX_W-1:0]   cfg_desc_idx,
    input  logic [31:0]        cfg_desc_base,
    input  logic [31:0]        cfg_desc_limit,
    input  logic [3:0]         cfg_desc_attr,
    input  logic               cfg_sel_we,
    input  logic [1:0]         cfg_sel_slot,
    input  logic [15:0]        cfg_sel_value,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [31:0]        req_offset,
    input  logic [1:0]         req_size,
    output logic               rsp_valid,
    output logic [31:0]        rsp_linear,
    output logic [1:0]         rsp_fault
);

    desc_t     wr_desc;
    desc_t     cur_desc;
    logic      cur_sel_bad;
    acc_kind_e kind;
    fault_e    chk_fault;
    logic [ADDR_W-1:0] chk_linear;
    result_t   res_q;

    assign kind    = acc_kind_e'(req_kind);
    assign wr_desc = '{base: cfg_desc_base, limit: cfg_desc_limit,
                       attr: attr_t'(cfg_desc_attr)};

    segchk_desc_table #(.NUM_DESC(NUM_DESC)) u_table (
        .clk          (clk),
        .rst          (rst),
        .desc_we      (cfg_desc_we),
        .desc_idx     (cfg_desc_idx),
        .desc_wdata   (wr_desc),
        .sel_we       (cfg_sel_we),
        .sel_slot     (cfg_sel_slot),
        .sel_wdata    (cfg_sel_value),
        .look_kind    (kind),
        .look_desc    (cur_desc),
        .look_sel_bad (cur_sel_bad)
    );

    segchk_rule_check u_check (
        .desc    (cur_desc),
        .sel_bad (cur_sel_bad),
        .kind    (kind),
        .offset  (req_offset),
        .size_m1 (req_size),
        .fault   (chk_fault),
        .linear  (chk_linear)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= req_valid;
            if (req_valid) begin
                res_q.fault  <= chk_fault;
                res_q.linear <= chk_linear;
            end
        end
    end

    assign rsp_valid  = res_q.valid;
    assign rsp_fault  = res_q.fault;
    assign rsp_linear = res_q.linear;

    // R2: one response exactly one cycle after each request
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8: a faulted response never exposes an address
    a_r8_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_linear == '0));

    // R7: an invalid selector outranks every other cause
    a_r7_sel_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_sel_bad) |=> (rsp_fault == 2'd3));

    // R5: a fetch through a descriptor without execute right is refused
    a_r5_fetch_needs_exec: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur_sel_bad && kind == ACC_FETCH && !cur_desc.attr.ex)
            |=> (rsp_fault == 2'd2));

endmodule

// File: tb/tb_segchk_top.sv
`timescale 1ns/1ps
module tb_segchk_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_desc_we;
    logic [2:0]  cfg_desc_idx;
    logic [31:0] cfg_desc_base;
    logic [31:0] cfg_desc_limit;
    logic [3:0]  cfg_desc_attr;
    logic        cfg_sel_we;
    logic [1:0]  cfg_sel_slot;
    logic [15:0] cfg_sel_value;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [31:0] req_offset;
    logic [1:0]  req_size;
    logic        rsp_valid;
    logic [31:0] rsp_linear;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [1:0] K_FETCH = 2'd0, K_READ = 2'd1, K_WRITE = 2'd2, K_STACK = 2'd3;
    localparam logic [1:0] F_NONE = 2'd0, F_LIMIT = 2'd1, F_TYPE = 2'd2, F_SEL = 2'd3;
    // attribute bits {wr, rd, ex, present}
    localparam logic [3:0] A_ALL  = 4'b1111;
    localparam logic [3:0] A_CODE = 4'b0111;
    localparam logic [3:0] A_DATA = 4'b1101;
    localparam logic [3:0] A_RO   = 4'b0101;

    always #2.5 clk = ~clk;

    segchk_top #(.NUM_DESC(8)) dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_desc(int idx, logic [31:0] base, logic [31:0] lim, logic [3:0] attr);
        @(negedge clk);
        cfg_desc_we = 1'b1; cfg_desc_idx = 3'(idx);
        cfg_desc_base = base; cfg_desc_limit = lim; cfg_desc_attr = attr;
        @(negedge clk);
        cfg_desc_we = 1'b0;
    endtask

    task automatic set_sel(logic [1:0] slot, logic [15:0] val);
        @(negedge clk);
        cfg_sel_we = 1'b1; cfg_sel_slot = slot; cfg_sel_value = val;
        @(negedge clk);
        cfg_sel_we = 1'b0;
    endtask

    task automatic access(string tag, logic [1:0] kind, logic [31:0] off, logic [1:0] sz,
                          logic [1:0] exp_f, logic [31:0] exp_lin);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_offset = off; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " fault"}, 32'(rsp_fault), 32'(exp_f));
        check({tag, " linear"}, rsp_linear, exp_lin);
    endtask

    task automatic t_reset();
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        access("R1 fetch before config", K_FETCH, 32'h10, 2'd0, F_SEL, 32'h0);
        access("R1 stack before config", K_STACK, 32'h10, 2'd0, F_SEL, 32'h0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        @(negedge clk);
        check("R2 idle no response", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_flat();
        set_desc(1, 32'h0, 32'hFFFF_FFFF, A_ALL);
        set_sel(2'd0, 16'h0008); set_sel(2'd1, 16'h0008); set_sel(2'd2, 16'h0008);
        access("R9 flat fetch", K_FETCH, 32'h1234_5678, 2'd0, F_NONE, 32'h1234_5678);
        access("R9 flat stack", K_STACK, 32'h8000_0000, 2'd3, F_NONE, 32'h8000_0000);
        access("R6 top of 4G", K_WRITE, 32'hFFFF_FFFC, 2'd3, F_NONE, 32'hFFFF_FFFC);
        access("R6 span past 4G", K_WRITE, 32'hFFFF_FFFD, 2'd3, F_LIMIT, 32'h0);
    endtask

    task automatic t_split();
        set_desc(2, 32'h1000_0000, 32'h0000_FFFF, A_CODE);
        set_desc(3, 32'h2000_0000, 32'h0000_0FFF, A_DATA);
        set_desc(4, 32'h3000_0000, 32'h0000_00FF, A_RO);
        set_sel(2'd0, 16'h0010); set_sel(2'd1, 16'h0018); set_sel(2'd2, 16'h0020);
        access("R3 R8 fetch via code", K_FETCH, 32'h10, 2'd0, F_NONE, 32'h1000_0010);
        access("R10 fetch beyond code", K_FETCH, 32'h0001_0000, 2'd0, F_LIMIT, 32'h0);
        access("R6 last byte at limit", K_READ, 32'hFFF, 2'd0, F_NONE, 32'h2000_0FFF);
        access("R6 one past limit", K_READ, 32'hFFF, 2'd1, F_LIMIT, 32'h0);
        access("R3 write via data", K_WRITE, 32'h20, 2'd1, F_NONE, 32'h2000_0020);
        access("R5 stack on read-only", K_STACK, 32'h4, 2'd0, F_TYPE, 32'h0);
        access("R7 type before limit", K_STACK, 32'h1000, 2'd0, F_TYPE, 32'h0);
    endtask

    task automatic t_swap();
        set_sel(2'd1, 16'h0010);
        access("R5 write to code seg", K_WRITE, 32'h8, 2'd0, F_TYPE, 32'h0);
        access("R5 read of code seg", K_READ, 32'h8, 2'd0, F_NONE, 32'h1000_0008);
        set_sel(2'd0, 16'h001F);
        access("R4 R10 fetch from data seg", K_FETCH, 32'h8, 2'd0, F_TYPE, 32'h0);
        set_sel(2'd0, 16'h0010); set_sel(2'd1, 16'h0018);
        set_sel(2'd3, 16'h0000);
        access("R3 slot3 ignored fetch", K_FETCH, 32'h4, 2'd0, F_NONE, 32'h1000_0004);
        access("R3 slot3 ignored read", K_READ, 32'h4, 2'd0, F_NONE, 32'h2000_0004);
    endtask

    task automatic t_bad_sel();
        set_sel(2'd2, 16'h0040);
        access("R4 index beyond table", K_STACK, 32'h0, 2'd0, F_SEL, 32'h0);
        set_sel(2'd2, 16'h0028);
        access("R4 absent entry", K_STACK, 32'h0, 2'd0, F_SEL, 32'h0);
        set_sel(2'd2, 16'h0007);
        access("R7 null selector over limit", K_STACK, 32'hFFFF_FFFF, 2'd3, F_SEL, 32'h0);
    endtask

    task automatic t_wrap_and_rewrite();
        set_desc(5, 32'hFFFF_FF00, 32'h0000_0FFF, A_ALL);
        set_sel(2'd1, 16'h0028);
        access("R8 base plus offset wraps", K_READ, 32'h200, 2'd0, F_NONE, 32'h0000_0100);
        // R11: rewrite and request in the same cycle
        @(negedge clk);
        cfg_desc_we = 1'b1; cfg_desc_idx = 3'd5;
        cfg_desc_base = 32'hFFFF_FF00; cfg_desc_limit = 32'hF; cfg_desc_attr = A_ALL;
        req_valid = 1'b1; req_kind = K_READ; req_offset = 32'h100; req_size = 2'd0;
        @(negedge clk);
        cfg_desc_we = 1'b0; req_valid = 1'b0;
        check("R11 same-cycle uses old fault", 32'(rsp_fault), 32'(F_NONE));
        check("R11 same-cycle uses old linear", rsp_linear, 32'h0);
        access("R11 next request sees new limit", K_READ, 32'h100, 2'd0, F_LIMIT, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_desc_we = 1'b0; cfg_desc_idx = '0; cfg_desc_base = '0;
        cfg_desc_limit = '0; cfg_desc_attr = '0;
        cfg_sel_we = 1'b0; cfg_sel_slot = '0; cfg_sel_value = '0;
        req_valid = 1'b0; req_kind = '0; req_offset = '0; req_size = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_flat();
        t_split();
        t_swap();
        t_bad_sel();
        t_wrap_and_rewrite();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule